// File: doc/BRIEF.md
# Serial Port Data FIFO Controller

This block sits between a CPU register interface and the shift engine of a synchronous serial port. It holds two word queues: one carries words from the CPU toward the serial line, and the other carries words from the line back to the CPU. The CPU reaches both queues through one data register. A control register sets two fill thresholds, a FIFO test-mode enable and a FIFO select bit. A status register holds two sticky error flags. Two level outputs, one for each queue, act as service requests. They tell the host when the transmit queue needs refilling and when the receive queue needs draining.

Serial words are WORD_W bits wide, from 4 to 16. Each is kept right-justified in a 16-bit entry. In test mode, every read and every write of the data register goes to the single queue chosen by the select bit. The serial side is cut off in that mode, so software can exercise each queue on its own.

Register map (reg_addr): 0 is the data register. 1 is control: bits [3:0] transmit threshold, [7:4] receive threshold, bit 8 test enable, bit 9 select (0 = transmit queue, 1 = receive queue). The control register resets to 0x0080. 2 is status: bit 0 overrun, bit 1 underrun, each cleared by writing 1. All other addresses and bits read as zero. Read data is registered: reg_rdata updates on the clock edge that samples reg_rd.

Top module: `sfc_top`

## Requirements
- R1: After reset both levels are 0, tx_req is 1, rx_req is 0, tx_valid is 0, the control register reads 0x0080 and the status register reads 0.
- R2: In normal mode a data-register write appends to the transmit queue. The serial side sees the oldest entry on tx_word while tx_valid is 1, and tx_pop removes that entry. Words leave in the order they were written.
- R3: In normal mode, rx_push stores rx_word in the receive queue. A data-register read returns and removes the oldest receive entry.
- R4: A CPU write keeps only the low WORD_W bits of reg_wdata. Every word read back through the data register is zero-extended to 16 bits.
- R5: tx_req is 1 exactly when the transmit level is at or below the transmit threshold. A threshold change shows from the cycle after the control write.
- R6: rx_req is 1 exactly when the receive level is at or above the receive threshold.
- R7: A write to a full queue is dropped and sets the sticky overrun flag (status bit 0). This covers both a CPU write and an rx_push. Writing 1 to that bit clears it.
- R8: A data-register read from an empty source queue returns 0 and sets the sticky underrun flag (status bit 1). Writing 1 to that bit clears it.
- R9: In test mode with select 0, data-register writes append to the transmit queue and data-register reads remove the oldest transmit entry.
- R10: In test mode with select 1, data-register writes append to the receive queue and data-register reads remove the oldest receive entry.
- R11: In test mode tx_valid is 0, tx_pop has no effect and rx_push stores nothing.
- R12: tx_level and rx_level report each queue's entry count, from 0 to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| tx_valid | output | 1 | Transmit word available to the shift engine |
| tx_word | output | WORD_W | Oldest transmit word |
| tx_pop | input | 1 | Shift engine takes the transmit word |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_word | input | WORD_W | Received word |
| tx_level | output | $clog2(DEPTH)+1 | Transmit queue count |
| rx_level | output | $clog2(DEPTH)+1 | Receive queue count |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |

## Verification
The routing of data-register accesses is tried under three patterns: normal mode, test mode aimed at the transmit queue, and test mode aimed at the receive queue. Levels are checked after each pattern, which shows which queue each access actually reached. Words with nonzero upper bits show that truncation and zero-extension happen, and runs of distinct values show that order is kept. Each threshold is moved across the current level to check the at-or-below and at-or-above edges. Both queues are filled one word past full, and a read is made from an empty queue, to show that drops and the sticky flags behave apart from normal traffic.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   localparam int ENTRY_W = 16;
   localparam int THR_W   = 4;

   localparam logic [1:0] A_DATA = 2'd0;
   localparam logic [1:0] A_CTRL = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;

   typedef struct packed {
      logic             sel_rx;
      logic             test_en;
      logic [THR_W-1:0] rx_thr;
      logic [THR_W-1:0] tx_thr;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{sel_rx: 1'b0, test_en: 1'b0,
                                    rx_thr: 4'd8, tx_thr: 4'd0};
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [W-1:0]             din,
   input  logic                     pop,
   output logic [W-1:0]             dout,
   output logic [$clog2(DEPTH):0]   level,
   output logic                     full,
   output logic                     empty
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("sfc_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   p_level_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
      level <= (AW+1)'(DEPTH));

   p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (level == (AW+1)'(DEPTH)));

   p_empty_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (level == '0));
endmodule

// File: rtl/sfc_svc_req.sv
module sfc_svc_req #(
   parameter int  LVL_W = 5,
   parameter int  THR_W = 4,
   parameter bit  ABOVE = 1'b0
) (
   input  logic [LVL_W-1:0] level,
   input  logic [THR_W-1:0] thr,
   output logic             req
);
   logic [LVL_W-1:0] thr_x;
   assign thr_x = LVL_W'(thr);

   if (ABOVE) begin : g_at_or_above
      assign req = (level >= thr_x);
   end else begin : g_at_or_below
      assign req = (level <= thr_x);
   end
endmodule

// File: rtl/sfc_top.sv
module sfc_top
   import sfc_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               reg_addr,
   input  logic                     reg_wr,
   input  logic                     reg_rd,
   input  logic [15:0]              reg_wdata,
   output logic [15:0]              reg_rdata,
   output logic                     tx_valid,
   output logic [WORD_W-1:0]        tx_word,
   input  logic                     tx_pop,
   input  logic                     rx_push,
   input  logic [WORD_W-1:0]        rx_word,
   output logic [$clog2(DEPTH):0]   tx_level,
   output logic [$clog2(DEPTH):0]   rx_level,
   output logic                     tx_req,
   output logic                     rx_req
);
   localparam int LVL_W = $clog2(DEPTH) + 1;

   if (WORD_W < 4 || WORD_W > ENTRY_W) begin : g_bad_word
      $error("sfc_top: WORD_W must lie in 4..16");
   end
   if (DEPTH > (1 << THR_W)) begin : g_bad_depth
      $error("sfc_top: DEPTH exceeds threshold range");
   end

   ctrl_t              ctrl_q;
   logic               ovr_q, unr_q;
   logic [ENTRY_W-1:0] cpu_word, ser_word;

   if (WORD_W == ENTRY_W) begin : g_full_width
      assign cpu_word = reg_wdata;
      assign ser_word = rx_word;
   end else begin : g_right_just
      assign cpu_word = {{(ENTRY_W-WORD_W){1'b0}}, reg_wdata[WORD_W-1:0]};
      assign ser_word = {{(ENTRY_W-WORD_W){1'b0}}, rx_word};
   end

   logic data_wr, data_rd, stat_wr, cpu_to_rx, cpu_from_tx;
   assign data_wr     = reg_wr && (reg_addr == A_DATA);
   assign data_rd     = reg_rd && (reg_addr == A_DATA);
   assign stat_wr     = reg_wr && (reg_addr == A_STAT);
   assign cpu_to_rx   = ctrl_q.test_en && ctrl_q.sel_rx;
   assign cpu_from_tx = ctrl_q.test_en && !ctrl_q.sel_rx;

   logic               txf_push, txf_pop, txf_full, txf_empty;
   logic               rxf_push, rxf_pop, rxf_full, rxf_empty;
   logic [ENTRY_W-1:0] txf_dout, rxf_dout, rxf_din;

   assign txf_push = data_wr && !cpu_to_rx;
   assign txf_pop  = cpu_from_tx ? data_rd : (tx_pop && !ctrl_q.test_en);
   assign rxf_push = cpu_to_rx ? data_wr : (rx_push && !ctrl_q.test_en);
   assign rxf_din  = cpu_to_rx ? cpu_word : ser_word;
   assign rxf_pop  = data_rd && !cpu_from_tx;

   sfc_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_txf (
      .clk(clk), .rst_n(rst_n), .push(txf_push), .din(cpu_word),
      .pop(txf_pop), .dout(txf_dout), .level(tx_level),
      .full(txf_full), .empty(txf_empty));

   sfc_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_rxf (
      .clk(clk), .rst_n(rst_n), .push(rxf_push), .din(rxf_din),
      .pop(rxf_pop), .dout(rxf_dout), .level(rx_level),
      .full(rxf_full), .empty(rxf_empty));

   sfc_svc_req #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b0)) u_txreq (
      .level(tx_level), .thr(ctrl_q.tx_thr), .req(tx_req));
   sfc_svc_req #(.LVL_W(LVL_W), .THR_W(THR_W), .ABOVE(1'b1)) u_rxreq (
      .level(rx_level), .thr(ctrl_q.rx_thr), .req(rx_req));

   assign tx_valid = !ctrl_q.test_en && !txf_empty;
   assign tx_word  = txf_dout[WORD_W-1:0];

   logic               src_empty, ovr_set, unr_set;
   logic [ENTRY_W-1:0] src_word;
   assign src_empty = cpu_from_tx ? txf_empty : rxf_empty;
   assign src_word  = cpu_from_tx ? txf_dout  : rxf_dout;
   assign ovr_set   = (txf_push && txf_full) || (rxf_push && rxf_full);
   assign unr_set   = data_rd && src_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= CTRL_RESET;
         ovr_q     <= 1'b0;
         unr_q     <= 1'b0;
         reg_rdata <= '0;
      end else begin
         if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
         ovr_q <= (ovr_q && !(stat_wr && reg_wdata[0])) || ovr_set;
         unr_q <= (unr_q && !(stat_wr && reg_wdata[1])) || unr_set;
         if (reg_rd) begin
            case (reg_addr)
               A_DATA:  reg_rdata <= src_empty ? '0 : src_word;
               A_CTRL:  reg_rdata <= 16'(ctrl_q);
               A_STAT:  reg_rdata <= {14'd0, unr_q, ovr_q};
               default: reg_rdata <= '0;
            endcase
         end
      end
   end

   p_sticky_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !(stat_wr && reg_wdata[0])) |=> ovr_q);

   p_sticky_unr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (unr_q && !(stat_wr && reg_wdata[1])) |=> unr_q);

   p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && src_empty) |=> (reg_rdata == '0));

   p_rx_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.test_en && !data_wr && !data_rd) |=> $stable(rx_level));

   p_tx_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.test_en && !data_wr && !data_rd) |=> $stable(tx_level));
endmodule

// File: tb/sim_sfc_top.sv
module sim_sfc_top;
   localparam int WORD_W = 8;
   localparam int DEPTH  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tx_valid, tx_pop = 1'b0, rx_push = 1'b0;
   logic [7:0]  tx_word, rx_word = '0;
   logic [4:0]  tx_level, rx_level;
   logic        tx_req, rx_req;

   always #5 clk = ~clk;

   sfc_top #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_valid(tx_valid), .tx_word(tx_word), .tx_pop(tx_pop),
      .rx_push(rx_push), .rx_word(rx_word), .tx_level(tx_level),
      .rx_level(rx_level), .tx_req(tx_req), .rx_req(rx_req));

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // op[36:34] addr[33:32] data[31:16] exp[15:0]
   // ops: 0 write, 1 read+check, 2 level/request check, 3 serial push,
   //      4 serial take+check word, 5 check tx_valid low and pulse tx_pop
   // level word: {tx_req, rx_req, 1'b0, tx_level, 3'b0, rx_level}
   localparam int NV = 37;
   localparam logic [36:0] VEC [NV] = '{
      {3'd2, 2'd0, 16'h0000, 16'h8000}, // R1 reset levels, requests
      {3'd1, 2'd1, 16'h0000, 16'h0080}, // R1 control reset
      {3'd1, 2'd2, 16'h0000, 16'h0000}, // R1 status reset
      {3'd0, 2'd0, 16'hAB12, 16'h0000}, // R2 R4 write, upper bits cut
      {3'd0, 2'd0, 16'h0034, 16'h0000}, // R2
      {3'd0, 2'd0, 16'h0056, 16'h0000}, // R2
      {3'd2, 2'd0, 16'h0000, 16'h0300}, // R12 tx 3, R5 req low
      {3'd0, 2'd1, 16'h0083, 16'h0000}, // R5 tx threshold 3
      {3'd2, 2'd0, 16'h0000, 16'h8300}, // R5 3 <= 3
      {3'd4, 2'd0, 16'h0000, 16'h0012}, // R2 R4 oldest first
      {3'd4, 2'd0, 16'h0000, 16'h0034}, // R2
      {3'd2, 2'd0, 16'h0000, 16'h8100}, // R12
      {3'd3, 2'd0, 16'h00C5, 16'h0000}, // R3 serial push
      {3'd3, 2'd0, 16'h007E, 16'h0000}, // R3
      {3'd0, 2'd1, 16'h0023, 16'h0000}, // R6 rx threshold 2
      {3'd2, 2'd0, 16'h0000, 16'hC102}, // R6 2 >= 2
      {3'd1, 2'd0, 16'h0000, 16'h00C5}, // R3 R4 read oldest, zero-ext
      {3'd2, 2'd0, 16'h0000, 16'h8101}, // R6 1 < 2
      {3'd1, 2'd0, 16'h0000, 16'h007E}, // R3
      {3'd1, 2'd0, 16'h0000, 16'h0000}, // R8 empty read gives 0
      {3'd1, 2'd2, 16'h0000, 16'h0002}, // R8 underrun set
      {3'd0, 2'd2, 16'h0002, 16'h0000}, // R8 clear
      {3'd1, 2'd2, 16'h0000, 16'h0000}, // R8 cleared
      {3'd0, 2'd1, 16'h0123, 16'h0000}, // R9 test mode, select tx
      {3'd3, 2'd0, 16'h0099, 16'h0000}, // R11 push ignored
      {3'd2, 2'd0, 16'h0000, 16'h8100}, // R11 rx still 0
      {3'd5, 2'd0, 16'h0000, 16'h0000}, // R11 tx_valid low, pop ignored
      {3'd2, 2'd0, 16'h0000, 16'h8100}, // R11 tx still 1
      {3'd0, 2'd0, 16'h00A1, 16'h0000}, // R9 write to tx
      {3'd1, 2'd0, 16'h0000, 16'h0056}, // R9 read pops tx
      {3'd1, 2'd0, 16'h0000, 16'h00A1}, // R9
      {3'd2, 2'd0, 16'h0000, 16'h8000}, // R9 both empty
      {3'd0, 2'd1, 16'h0323, 16'h0000}, // R10 select rx
      {3'd0, 2'd0, 16'h1234, 16'h0000}, // R10 R4 write to rx
      {3'd2, 2'd0, 16'h0000, 16'h8001}, // R10 rx 1
      {3'd1, 2'd0, 16'h0000, 16'h0034}, // R10 read pops rx
      {3'd0, 2'd1, 16'h0083, 16'h0000}  // back to normal mode
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
   endtask

   task automatic spush(input logic [7:0] w);
      @(negedge clk); rx_word = w; rx_push = 1'b1;
      @(negedge clk); rx_push = 1'b0;
   endtask

   function automatic logic [15:0] lvl();
      return {tx_req, rx_req, 1'b0, tx_level, 3'b0, rx_level};
   endfunction

   task automatic stake(input string tag, input logic [15:0] exp);
      @(negedge clk);
      check(tag, {7'd0, tx_valid, tx_word}, {8'h01, exp[7:0]});
      tx_pop = 1'b1;
      @(negedge clk); tx_pop = 1'b0;
   endtask

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         case (VEC[i][36:34])
            3'd0: wr(VEC[i][33:32], VEC[i][31:16]);
            3'd1: begin rd(VEC[i][33:32], d); check($sformatf("vec%0d rdata", i), d, VEC[i][15:0]); end
            3'd2: begin @(negedge clk); check($sformatf("vec%0d level", i), lvl(), VEC[i][15:0]); end
            3'd3: spush(VEC[i][23:16]);
            3'd4: stake($sformatf("vec%0d tx_word", i), VEC[i][15:0]);
            default: begin
               @(negedge clk);
               check($sformatf("vec%0d R11 tx_valid", i), {15'd0, tx_valid}, 16'd0);
               tx_pop = 1'b1;
               @(negedge clk); tx_pop = 1'b0;
            end
         endcase
      end

      // R7 transmit overflow, R12 full level, R2 order over a full queue
      for (int i = 0; i < DEPTH + 1; i++) wr(2'd0, 16'h0100 + 16'(i));
      @(negedge clk); check("R12 R7 tx full level", lvl(), 16'h1000);
      rd(2'd2, d); check("R7 overrun set", d, 16'h0001);
      wr(2'd2, 16'h0001);
      rd(2'd2, d); check("R7 overrun cleared", d, 16'h0000);
      for (int i = 0; i < DEPTH; i++) stake("R2 drain order", 16'(i));
      @(negedge clk); check("R2 tx_valid after drain", {15'd0, tx_valid}, 16'd0);

      // R7 receive overflow through the serial side, R6 full
      for (int j = 0; j < DEPTH + 1; j++) spush(8'h40 + 8'(j));
      @(negedge clk); check("R6 R12 rx full level", lvl(), 16'hC010);
      rd(2'd2, d); check("R7 serial overrun", d, 16'h0001);
      rd(2'd0, d); check("R3 first rx kept", d, 16'h0040);

      // R1 reset with data queued
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk); check("R1 levels after reset", lvl(), 16'h8000);
      rd(2'd1, d); check("R1 control after reset", d, 16'h0080);
      rd(2'd2, d); check("R1 status after reset", d, 16'h0000);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule